// File: doc/BRIEF.md
# Four-Channel Byte DMA Engine

This block moves single bytes without processor help once a channel has been set up. Each of its four channels has a request/acknowledge pair toward one peripheral. When a peripheral raises its request, the engine runs one cycle on a byte-wide memory master port. In that cycle it either stores the peripheral's byte at the channel's current address or fetches a byte from that address for the peripheral. The channel's address then steps up or down, and its count steps down.

Software sets each channel through a small write port. The port loads a 16-bit base address, a 16-bit base count, a mode word and an 8-bit page. The page is placed above the 16-bit address and is never altered by transfers, so stepping wraps inside one 64 KiB window. Channel 0 can also be switched to copy memory to memory. Each grant then reads a byte at channel 0's address into a one-byte holding register, and writes it on the next cycle at channel 1's address. A terminal-count output marks the last byte of a channel. A readable sticky flag per channel records that the channel finished.

Top module: `dma4_top`

## Requirements
- R1: After reset no memory cycle, acknowledge, terminal count or status flag is active, and every channel is masked, so requests on any line start no cycle.
- R2: Each granted peripheral request produces exactly one memory cycle lasting one clock. It is followed by at least one clock with `mem_req` low before the next grant.
- R3: When several unmasked requests are pending, the lowest-numbered channel is served first.
- R4: Mode bit 3 picks the direction. When it is 0, the cycle is a write (`mem_we`=1) of `io_din` to {page, current address}. When it is 1, it is a read from that address, and `io_dout` carries `mem_rdata`.
- R5: After each transfer the current address moves by +1 when mode bit 0 is 0, or by -1 when it is 1, and the current count drops by one.
- R6: `tc` is high during the transfer cycle in which the channel's current count is zero. A base count of N therefore gives N+1 transfers, with `tc` on the last.
- R7: Mode bit 2 written as 1 masks a channel, and written as 0 unmasks it. At terminal count a channel whose auto-reload bit is 0 becomes masked, and its later requests start no cycle.
- R8: Mode bit 1 set makes a channel reload its current address and count from the base values at terminal count, and the channel stays unmasked.
- R9: The 16-bit address wraps from 0xFFFF to 0x0000, or from 0x0000 to 0xFFFF, while the page bits on `mem_addr[23:16]` stay unchanged.
- R10: With mode bit 4 of channel 0 set, a channel 0 request starts a copy. The first cycle reads from channel 0's address with no acknowledge. The next cycle writes that same byte to channel 1's address. Terminal count comes from channel 1's count, and channel 1's own request line is ignored.
- R11: `stat[i]` is set by a terminal count on channel i and stays set until a clock with `stat_rd` high clears it. In a copy, the flag of channel 1 is the one set.
- R12: At most one acknowledge is high at a time, and only during that channel's memory cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | 2 | Channel addressed by the write |
| cfg_sel | input | 2 | 0 base address, 1 base count, 2 mode, 3 page |
| cfg_data | input | 16 | Write data |
| dreq | input | 4 | Peripheral requests, one per channel |
| dack | output | 4 | Acknowledges, one per channel |
| io_din | input | 8 | Byte from the peripheral |
| io_dout | output | 8 | Byte to the peripheral |
| mem_req | output | 1 | Memory cycle active |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 24 | {page, 16-bit address} |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the cycle |
| tc | output | 1 | Terminal count pulse |
| stat_rd | input | 1 | Clears the status flags |
| stat | output | 4 | Sticky terminal-count flags |

## Verification
A vector table runs each channel once, mixing the two step directions with both transfer directions. Its starting addresses sit at 0xFFFF and 0x0000, so a wrong carry into the page or a wrong step sign shows on the second address. Directed runs follow. Two channels request at once to expose the priority order. A two-transfer channel separates the count that gives the terminal pulse from an off-by-one, then confirms the automatic mask and the status clear. A zero-count auto-reload channel must repeat its first address. Copies move known bytes so that the held byte and the source of the terminal count can be checked.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
   typedef enum logic [1:0] {SEL_ADDR, SEL_CNT, SEL_MODE, SEL_PAGE} sel_e;
   typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_CP_RD, ST_CP_WR} st_e;
   localparam int MB_DEC  = 0;
   localparam int MB_AUTO = 1;
   localparam int MB_MASK = 2;
   localparam int MB_RD   = 3;
   localparam int MB_CPY  = 4;
   localparam int MODE_W  = 5;
endpackage

// File: rtl/dma4_chan.sv
module dma4_chan
   import dma4_pkg::*;
#(
   parameter int AW = 16,
   parameter int PW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  sel_e              wr_sel,
   input  logic [AW-1:0]     wr_data,
   input  logic              step,
   input  logic              last,
   output logic [AW-1:0]     addr_o,
   output logic [PW-1:0]     page_o,
   output logic [MODE_W-1:0] mode_o,
   output logic              masked_o,
   output logic              zero_o
);
   logic [AW-1:0]     base_addr, base_cnt, cur_addr, cur_cnt;
   logic [PW-1:0]     page;
   logic [MODE_W-1:0] mode;
   logic              masked;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_addr <= '0;
         base_cnt  <= '0;
         cur_addr  <= '0;
         cur_cnt   <= '0;
         page      <= '0;
         mode      <= '0;
         masked    <= 1'b1;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_ADDR: begin base_addr <= wr_data; cur_addr <= wr_data; end
            SEL_CNT:  begin base_cnt  <= wr_data; cur_cnt  <= wr_data; end
            SEL_MODE: begin mode <= wr_data[MODE_W-1:0]; masked <= wr_data[MB_MASK]; end
            SEL_PAGE: page <= wr_data[PW-1:0];
         endcase
      end else if (step) begin
         if (last && mode[MB_AUTO]) begin
            cur_addr <= base_addr;
            cur_cnt  <= base_cnt;
         end else begin
            cur_addr <= mode[MB_DEC] ? cur_addr - 1'b1 : cur_addr + 1'b1;
            cur_cnt  <= cur_cnt - 1'b1;
            if (last) masked <= 1'b1;
         end
      end
   end

   assign addr_o   = cur_addr;
   assign page_o   = page;
   assign mode_o   = mode;
   assign masked_o = masked;
   assign zero_o   = (cur_cnt == '0);
endmodule

// File: rtl/dma4_arb.sv
module dma4_arb #(
   parameter int N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   always_comb begin
      logic found;
      found = 1'b0;
      gnt   = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !found) begin
            gnt[i] = 1'b1;
            found  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/dma4_top.sv
module dma4_top
   import dma4_pkg::*;
#(
   parameter int NCH = 4,
   parameter int AW  = 16,
   parameter int PW  = 8,
   parameter int DW  = 8,
   localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int MAW = PW + AW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_we,
   input  logic [CW-1:0]  cfg_chan,
   input  logic [1:0]     cfg_sel,
   input  logic [AW-1:0]  cfg_data,
   input  logic [NCH-1:0] dreq,
   output logic [NCH-1:0] dack,
   input  logic [DW-1:0]  io_din,
   output logic [DW-1:0]  io_dout,
   output logic           mem_req,
   output logic           mem_we,
   output logic [MAW-1:0] mem_addr,
   output logic [DW-1:0]  mem_wdata,
   input  logic [DW-1:0]  mem_rdata,
   output logic           tc,
   input  logic           stat_rd,
   output logic [NCH-1:0] stat
);
   if (NCH < 2 || NCH > 8) begin : g_bad_nch
      $error("dma4_top: NCH must be 2..8");
   end
   if (PW > AW || MODE_W > AW) begin : g_bad_aw
      $error("dma4_top: PW and mode width must fit in AW");
   end

   logic [AW-1:0]     addr_a [NCH];
   logic [PW-1:0]     page_a [NCH];
   logic [MODE_W-1:0] mode_a [NCH];
   logic [NCH-1:0]    masked, zero, step, elig, gnt;
   st_e               st;
   logic [CW-1:0]     gsel, gidx, asel;
   logic [DW-1:0]     hold;
   logic [NCH-1:0]    sticky;
   logic              cpy_on;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      dma4_chan #(.AW(AW), .PW(PW)) u_ch (
         .clk(clk), .rst_n(rst_n),
         .wr_en(cfg_we && cfg_chan == CW'(i)),
         .wr_sel(sel_e'(cfg_sel)), .wr_data(cfg_data),
         .step(step[i]), .last(tc),
         .addr_o(addr_a[i]), .page_o(page_a[i]), .mode_o(mode_a[i]),
         .masked_o(masked[i]), .zero_o(zero[i]));
      if (i == 1) begin : g_dst
         assign elig[i] = dreq[i] && !masked[i] && !cpy_on;
      end else begin : g_src
         assign elig[i] = dreq[i] && !masked[i];
      end
      assign dack[i] = (st == ST_XFER) && (gsel == CW'(i));
      assign step[i] = dack[i] || ((st == ST_CP_WR) && (i < 2));
   end

   assign cpy_on = mode_a[0][MB_CPY];

   dma4_arb #(.N(NCH)) u_arb (.req(elig), .gnt(gnt));

   always_comb begin
      gidx = '0;
      for (int i = 0; i < NCH; i++) if (gnt[i]) gidx = CW'(i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         gsel <= '0;
         hold <= '0;
      end else begin
         case (st)
            ST_IDLE: if (|gnt) begin
               gsel <= gidx;
               st   <= (gnt[0] && cpy_on) ? ST_CP_RD : ST_XFER;
            end
            ST_CP_RD: begin
               hold <= mem_rdata;
               st   <= ST_CP_WR;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      case (st)
         ST_CP_RD: asel = '0;
         ST_CP_WR: asel = CW'(1);
         default:  asel = gsel;
      endcase
   end

   assign mem_req   = (st != ST_IDLE);
   assign mem_addr  = {page_a[asel], addr_a[asel]};
   assign mem_we    = ((st == ST_XFER) && !mode_a[gsel][MB_RD]) || (st == ST_CP_WR);
   assign mem_wdata = (st == ST_CP_WR) ? hold : io_din;
   assign io_dout   = mem_rdata;
   assign tc        = ((st == ST_XFER) && zero[gsel]) || ((st == ST_CP_WR) && zero[1]);

   always_ff @(posedge clk) begin
      if (!rst_n) sticky <= '0;
      else begin
         for (int i = 0; i < NCH; i++) begin
            if (tc && (dack[i] || ((st == ST_CP_WR) && i == 1))) sticky[i] <= 1'b1;
            else if (stat_rd) sticky[i] <= 1'b0;
         end
      end
   end
   assign stat = sticky;
endmodule

// File: rtl/dma4_chk.sv
module dma4_chk #(
   parameter int NCH = 4,
   parameter int DW  = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NCH-1:0] dack,
   input logic           mem_req,
   input logic           mem_we,
   input logic [DW-1:0]  mem_wdata,
   input logic [DW-1:0]  mem_rdata,
   input logic           tc
);
   a_r12_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dack));
   a_r12_ack_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (|dack) |-> mem_req);
   a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
      (|dack) |=> !mem_req);
   a_r10_copy_order: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && dack == '0) |=> (mem_req && mem_we && dack == '0));
   a_r10_copy_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && dack == '0) |=> (mem_wdata == $past(mem_rdata)));
   a_r6_tc_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      tc |-> mem_req);
endmodule

bind dma4_top dma4_chk #(.NCH(NCH), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .dack(dack), .mem_req(mem_req), .mem_we(mem_we),
   .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .tc(tc));

// File: tb/dma4_top_test.sv
`timescale 1ns/1ps
module dma4_top_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_chan = '0;
   logic [1:0]  cfg_sel = '0;
   logic [15:0] cfg_data = '0;
   logic [3:0]  dreq = '0;
   logic [3:0]  dack;
   logic [7:0]  io_din = '0;
   logic [7:0]  io_dout;
   logic        mem_req, mem_we;
   logic [23:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata;
   logic        tc;
   logic        stat_rd = 1'b0;
   logic [3:0]  stat;
   int total = 0;
   int bad = 0;
   logic [7:0] mem [16];

   always #4 clk = ~clk;

   dma4_top uut (.*);

   assign mem_rdata = mem[mem_addr[3:0]];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) mem[i] <= 8'(i * 17);
      end else if (mem_req && mem_we) mem[mem_addr[3:0]] <= mem_wdata;
   end

   // row: ch[43:42] dec[41] rd[40] page[39:32] start[31:16] second[15:0]
   localparam logic [43:0] VEC [4] = '{
      {2'd0, 1'b0, 1'b0, 8'h12, 16'h1000, 16'h1001},
      {2'd1, 1'b1, 1'b0, 8'h34, 16'h2000, 16'h1FFF},
      {2'd2, 1'b0, 1'b0, 8'h56, 16'hFFFF, 16'h0000},
      {2'd3, 1'b1, 1'b1, 8'h78, 16'h0000, 16'hFFFF}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cfg(input int ch, input int sel, input logic [15:0] d);
      cfg_we = 1'b1; cfg_chan = 2'(ch); cfg_sel = 2'(sel); cfg_data = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic setup(input int ch, input logic [7:0] pg, input logic [15:0] a,
                        input logic [15:0] n, input logic [15:0] md);
      cfg(ch, 0, a); cfg(ch, 1, n); cfg(ch, 3, {8'h00, pg}); cfg(ch, 2, md);
   endtask

   task automatic xfer(input int ch, output logic [23:0] a, output logic we,
                       output logic [7:0] wd, output logic t, output logic [7:0] dout);
      bit seen = 0;
      dreq[ch] = 1'b1;
      for (int k = 0; k < 10 && !seen; k++) begin
         @(negedge clk);
         if (dack[ch]) seen = 1;
      end
      a = mem_addr; we = mem_we; wd = mem_wdata; t = tc; dout = io_dout;
      if (!seen) a = 24'hxxxxxx;
      dreq[ch] = 1'b0;
      @(negedge clk);
   endtask

   task automatic quiet(input string req, input int ch);
      bit any = 0;
      dreq[ch] = 1'b1;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         if (mem_req) any = 1;
      end
      dreq[ch] = 1'b0;
      check(req, 32'(any), 0);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [23:0] a; logic we, t; logic [7:0] wd, dout;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 mem_req", 32'(mem_req), 0);
      check("R1 dack", 32'(dack), 0);
      check("R1 tc", 32'(tc), 0);
      check("R1 stat", 32'(stat), 0);
      dreq = 4'hF;
      repeat (3) begin @(negedge clk); check("R1 masked after reset", 32'(mem_req), 0); end
      dreq = 4'h0;
      @(negedge clk);

      // vector table: R4 R5 R9
      for (int r = 0; r < 4; r++) begin
         int ch = int'(VEC[r][43:42]);
         logic [7:0] pg = VEC[r][39:32];
         setup(ch, pg, VEC[r][31:16], 16'd5, {11'd0, 1'b0, VEC[r][40], 1'b0, 1'b0, VEC[r][41]});
         io_din = 8'hC0 + 8'(r);
         xfer(ch, a, we, wd, t, dout);
         check("R4 first address", 32'(a), 32'({pg, VEC[r][31:16]}));
         check("R4 direction", 32'(we), 32'(!VEC[r][40]));
         if (!VEC[r][40]) check("R4 write data", 32'(wd), 32'(8'hC0 + 8'(r)));
         else check("R4 read data to peripheral", 32'(dout), 32'(mem[a[3:0]]));
         check("R6 no tc early", 32'(t), 0);
         xfer(ch, a, we, wd, t, dout);
         check("R5 R9 second address", 32'(a), 32'({pg, VEC[r][15:0]}));
         cfg(ch, 2, 16'h0004);
      end

      // R3 priority, R2 release
      setup(1, 8'h00, 16'h0500, 16'd5, 16'h0000);
      setup(2, 8'h00, 16'h0600, 16'd5, 16'h0000);
      dreq = 4'b0110;
      @(negedge clk);
      check("R3 lowest channel first", 32'(dack), 32'h2);
      dreq[1] = 1'b0;
      @(negedge clk);
      check("R2 idle between grants", 32'(mem_req), 0);
      @(negedge clk);
      check("R3 next channel", 32'(dack), 32'h4);
      dreq[2] = 1'b0;
      @(negedge clk);
      cfg(1, 2, 16'h0004); cfg(2, 2, 16'h0004);

      // R6 tc on last, R11 status, R7 auto mask
      setup(2, 8'h00, 16'h0100, 16'd1, 16'h0000);
      xfer(2, a, we, wd, t, dout);
      check("R6 tc low on first", 32'(t), 0);
      xfer(2, a, we, wd, t, dout);
      check("R6 tc on last", 32'(t), 1);
      check("R11 flag set", 32'(stat), 32'h4);
      @(negedge clk);
      check("R11 flag sticky", 32'(stat), 32'h4);
      stat_rd = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0;
      check("R11 flag cleared by read", 32'(stat), 0);
      quiet("R7 masked at tc", 2);

      // R8 auto reload
      setup(3, 8'h00, 16'h0040, 16'd0, 16'h0002);
      xfer(3, a, we, wd, t, dout);
      check("R8 first address", 32'(a), 32'h000040);
      check("R8 tc", 32'(t), 1);
      xfer(3, a, we, wd, t, dout);
      check("R8 reloaded address", 32'(a), 32'h000040);
      check("R8 tc again", 32'(t), 1);
      cfg(3, 2, 16'h0004);
      stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;

      // R10 memory copy
      setup(1, 8'h00, 16'h0009, 16'd1, 16'h0000);
      setup(0, 8'h00, 16'h0002, 16'd7, 16'h0010);
      for (int n = 0; n < 2; n++) begin
         dreq[0] = 1'b1;
         @(negedge clk);
         check("R10 read step", 32'({mem_req, mem_we, dack}), 32'({1'b1, 1'b0, 4'h0}));
         check("R10 source address", 32'(mem_addr), 32'(24'h2 + 24'(n)));
         @(negedge clk);
         check("R10 write step", 32'({mem_req, mem_we, dack}), 32'({1'b1, 1'b1, 4'h0}));
         check("R10 dest address", 32'(mem_addr), 32'(24'h9 + 24'(n)));
         check("R10 tc from channel 1", 32'(tc), 32'(n));
         dreq[0] = 1'b0;
         @(negedge clk);
      end
      check("R10 first byte copied", 32'(mem[9]), 32'h22);
      check("R10 second byte copied", 32'(mem[10]), 32'h33);
      check("R11 copy flag on channel 1", 32'(stat), 32'h2);
      quiet("R10 R7 copy stops at tc", 0);
      dreq[1] = 1'b1;
      cfg(1, 2, 16'h0000);
      repeat (3) begin @(negedge clk); check("R10 channel 1 request ignored", 32'(mem_req), 0); end
      dreq[1] = 1'b0;

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule